// File: doc/BRIEF.md
# Ping-Pong Circular Write Channel

This block is one peripheral-to-memory transfer channel that writes into two memory regions in turn. A peripheral offers words through a request/acknowledge handshake. The channel places each word into the active region through a simple memory write port that uses address, data, valid and ready. It steps the address by one word after every accepted write. When the programmed number of words has gone into one region, the channel switches to the other region, restarts at that region's base, reloads its word counter and keeps running. Software is not involved in the switch. Meanwhile, another agent can drain the region that was just filled.

Every completed region raises a completion flag. The flag stays set until a clear write arrives whose bit mask selects it. The flag is meant to be wired straight to a second transfer engine as its trigger. A `buffer` output shows which region is currently being written. A sticky overrun bit records a completion that landed while the previous flag was still unacknowledged. The channel stops only when software drops the enable. If software drops the enable partway through a region, that also raises the completion flag.

The control sequence has three states. `ST_IDLE` is the disabled state. `ST_WAIT` waits for a peripheral request. `ST_WRITE` holds a write on the memory port until it is accepted. The transitions are:
- start: `ST_IDLE` to `ST_WAIT`, when the enable is set and the count is nonzero.
- take: `ST_WAIT` to `ST_WRITE`, when a request is acknowledged.
- done: `ST_WRITE` to `ST_WAIT`, when the write is accepted.
- stop: `ST_WAIT` to `ST_IDLE`, when the enable is low.

Top module: `dbuf_dma_chan`

## Requirements
- R1: After reset, `mem_valid`, `per_ack`, `tc_flag`, `overrun` and `buffer` are all 0.
- R2: After start, the first write goes to `cfg_base0`. Each later accepted write within a region goes to the previous address plus WORD_BYTES (default 4). The data values appear in the order the peripheral handed them over.
- R3: After `cfg_count` accepted writes into one region, `buffer` toggles and the next write goes to the other region's base. The counter reloads and transfers continue with no software action, cycling 0,1,0,1 indefinitely.
- R4: `tc_flag` is 1 in the cycle after the final write of a region is accepted.
- R5: A cycle with `clr_valid`=1 and `clr_mask` bit TC_BIT (default bit 0) set clears `tc_flag` on the next cycle. Mask bits other than TC_BIT and OVR_BIT have no effect. A completion in the same cycle as a clear leaves the flag set.
- R6: A completion that occurs while `tc_flag` is 1 and is not being cleared sets `overrun`. `overrun` stays 1 until a clear write with mask bit OVR_BIT (default bit 1).
- R7: While `mem_valid`=1 and `mem_ready`=0, `mem_valid`, `mem_addr` and `mem_data` hold, and no new peripheral word is acknowledged.
- R8: `per_ack` is 1 only when the channel is enabled, is waiting with no write pending, and sees `per_req`=1. Each acknowledge transfers exactly one word.
- R9: Clearing `cfg_enable` takes effect once no write is pending, and the channel goes idle. If part of the current region has been written, `tc_flag` is set. If the region boundary was just crossed, the flag is not set. A later start resumes at `cfg_base0` with `buffer`=0.
- R10: Setting `cfg_enable` with `cfg_count`=0 leaves the channel idle with no acknowledges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_enable | input | 1 | Channel run enable |
| cfg_base0 | input | ADDR_W | Base address of region 0 |
| cfg_base1 | input | ADDR_W | Base address of region 1 |
| cfg_count | input | CNT_W | Words per region |
| per_req | input | 1 | Peripheral has a word |
| per_data | input | DATA_W | Peripheral word |
| per_ack | output | 1 | Word taken this cycle |
| mem_addr | output | ADDR_W | Write address |
| mem_data | output | DATA_W | Write data |
| mem_valid | output | 1 | Write pending |
| mem_ready | input | 1 | Memory accepts the write |
| clr_valid | input | 1 | Clear write strobe |
| clr_mask | input | MASK_W | Clear bit mask |
| tc_flag | output | 1 | Region completion flag |
| overrun | output | 1 | Sticky missed-acknowledge status |
| buffer | output | 1 | Region currently being written |

## Verification
- `per_ack` is combinational, so it is visible in the same cycle as the request.
- A word acknowledged at one edge appears on the memory port one cycle later.
- `tc_flag`, `overrun`, `buffer` and the next address all change at the same edge that accepts the final write of a region.
- A clear or a disable changes the flags one edge after it is applied.

The bench logs writes and acknowledges at rising edges. It drives stimulus and reads results at falling edges, so every check samples a full half-period after the edge that produced the value.

// File: rtl/dbuf_pkg.sv
package dbuf_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_WRITE = 2'd2
    } chan_state_e;
endpackage

// File: rtl/dbuf_ptr.sv
module dbuf_ptr #(
    parameter int ADDR_W     = 32,
    parameter int CNT_W      = 16,
    parameter int WORD_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              wdone,
    input  logic [ADDR_W-1:0] base0,
    input  logic [ADDR_W-1:0] base1,
    input  logic [CNT_W-1:0]  count,
    output logic [ADDR_W-1:0] addr,
    output logic              last,
    output logic              partial,
    output logic              sel
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);
    localparam logic [CNT_W-1:0]  ONE  = CNT_W'(1);

    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  left_q;
    logic [CNT_W-1:0]  load_q;
    logic              sel_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            left_q <= '0;
            load_q <= '0;
            sel_q  <= 1'b0;
        end else if (start) begin
            addr_q <= base0;
            left_q <= count;
            load_q <= count;
            sel_q  <= 1'b0;
        end else if (wdone) begin
            if (left_q == ONE) begin
                sel_q  <= ~sel_q;
                addr_q <= sel_q ? base0 : base1;
                left_q <= load_q;
            end else begin
                addr_q <= addr_q + STEP;
                left_q <= left_q - ONE;
            end
        end
    end

    assign addr    = addr_q;
    assign last    = (left_q == ONE);
    assign partial = (left_q != load_q);
    assign sel     = sel_q;
endmodule

// File: rtl/dbuf_flags.sv
module dbuf_flags #(
    parameter int MASK_W  = 8,
    parameter int TC_BIT  = 0,
    parameter int OVR_BIT = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set,
    input  logic              clr_valid,
    input  logic [MASK_W-1:0] clr_mask,
    output logic              tc_hit,
    output logic              ovr_hit,
    output logic              tc,
    output logic              ovr
);
    logic tc_q, ovr_q;

    assign tc_hit  = clr_valid && clr_mask[TC_BIT];
    assign ovr_hit = clr_valid && clr_mask[OVR_BIT];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tc_q  <= 1'b0;
            ovr_q <= 1'b0;
        end else begin
            if (set)
                tc_q <= 1'b1;
            else if (tc_hit)
                tc_q <= 1'b0;

            if (set && tc_q && !tc_hit)
                ovr_q <= 1'b1;
            else if (ovr_hit)
                ovr_q <= 1'b0;
        end
    end

    assign tc  = tc_q;
    assign ovr = ovr_q;
endmodule

// File: rtl/dbuf_dma_chan.sv
module dbuf_dma_chan
    import dbuf_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int CNT_W      = 16,
    parameter int WORD_BYTES = 4,
    parameter int MASK_W     = 8,
    parameter int TC_BIT     = 0,
    parameter int OVR_BIT    = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_enable,
    input  logic [ADDR_W-1:0] cfg_base0,
    input  logic [ADDR_W-1:0] cfg_base1,
    input  logic [CNT_W-1:0]  cfg_count,
    input  logic              per_req,
    input  logic [DATA_W-1:0] per_data,
    output logic              per_ack,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_data,
    output logic              mem_valid,
    input  logic              mem_ready,
    input  logic              clr_valid,
    input  logic [MASK_W-1:0] clr_mask,
    output logic              tc_flag,
    output logic              overrun,
    output logic              buffer
);
    chan_state_e state_q, state_d;

    logic              go_start, go_take, go_done, go_stop;
    logic              buf_last, buf_partial;
    logic              tc_set, clr_tc_hit, clr_ovr_hit;
    logic [DATA_W-1:0] data_q;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (go_start) state_d = ST_WAIT;
            ST_WAIT:  if (go_stop)  state_d = ST_IDLE;
                      else if (go_take) state_d = ST_WRITE;
            ST_WRITE: if (go_done)  state_d = ST_WAIT;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        go_start  = (state_q == ST_IDLE) && cfg_enable && (cfg_count != '0);
        go_stop   = (state_q == ST_WAIT) && !cfg_enable;
        go_take   = (state_q == ST_WAIT) && cfg_enable && per_req;
        go_done   = (state_q == ST_WRITE) && mem_ready;
        per_ack   = go_take;
        mem_valid = (state_q == ST_WRITE);
        tc_set    = (go_done && buf_last) || (go_stop && buf_partial);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       data_q <= '0;
        else if (go_take) data_q <= per_data;
    end

    dbuf_ptr #(
        .ADDR_W(ADDR_W), .CNT_W(CNT_W), .WORD_BYTES(WORD_BYTES)
    ) u_ptr (
        .clk(clk), .rst_n(rst_n), .start(go_start), .wdone(go_done),
        .base0(cfg_base0), .base1(cfg_base1), .count(cfg_count),
        .addr(mem_addr), .last(buf_last), .partial(buf_partial), .sel(buffer)
    );

    dbuf_flags #(
        .MASK_W(MASK_W), .TC_BIT(TC_BIT), .OVR_BIT(OVR_BIT)
    ) u_flags (
        .clk(clk), .rst_n(rst_n), .set(tc_set),
        .clr_valid(clr_valid), .clr_mask(clr_mask),
        .tc_hit(clr_tc_hit), .ovr_hit(clr_ovr_hit),
        .tc(tc_flag), .ovr(overrun)
    );

    assign mem_data = data_q;
endmodule

// File: rtl/dbuf_dma_chan_chk.sv
module dbuf_dma_chan_chk #(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int WORD_BYTES = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_enable,
    input logic              per_req,
    input logic              per_ack,
    input logic              mem_valid,
    input logic              mem_ready,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_data,
    input logic              tc_flag,
    input logic              overrun,
    input logic              buffer,
    input logic              tc_set,
    input logic              buf_last,
    input logic              clr_tc_hit
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

    a_r2_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_ready && !buf_last) |=> (mem_addr == $past(mem_addr) + STEP));

    a_r3_swap: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_ready && buf_last) |=> (buffer != $past(buffer)));

    a_r4_tc_set: assert property (@(posedge clk) disable iff (!rst_n)
        tc_set |=> tc_flag);

    a_r5_tc_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_tc_hit && !tc_set) |=> !tc_flag);

    a_r6_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_set && tc_flag && !clr_tc_hit) |=> overrun);

    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data)));

    a_r8_ack_gate: assert property (@(posedge clk) disable iff (!rst_n)
        per_ack |-> (per_req && cfg_enable && !mem_valid));
endmodule

bind dbuf_dma_chan dbuf_dma_chan_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORD_BYTES(WORD_BYTES)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .per_req(per_req),
    .per_ack(per_ack), .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_addr(mem_addr), .mem_data(mem_data), .tc_flag(tc_flag),
    .overrun(overrun), .buffer(buffer), .tc_set(tc_set),
    .buf_last(buf_last), .clr_tc_hit(clr_tc_hit)
);

// File: tb/tb_dbuf_dma_chan.sv
module tb_dbuf_dma_chan;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_enable = 1'b0;
    logic [31:0] cfg_base0 = 32'h0000_1000;
    logic [31:0] cfg_base1 = 32'h0000_2000;
    logic [15:0] cfg_count = 16'd4;
    logic        per_req = 1'b0;
    logic [31:0] per_data;
    logic        per_ack;
    logic [31:0] mem_addr, mem_data;
    logic        mem_valid;
    logic        mem_ready = 1'b1;
    logic        clr_valid = 1'b0;
    logic [7:0]  clr_mask = 8'h00;
    logic        tc_flag, overrun, buffer;

    int checks = 0;
    int failures = 0;

    logic [31:0] src_q = 32'h100;
    int          nwr = 0;
    int          nack = 0;
    logic [31:0] log_addr [0:63];
    logic [31:0] log_data [0:63];

    always #5 clk = ~clk;

    dbuf_dma_chan dut (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable),
        .cfg_base0(cfg_base0), .cfg_base1(cfg_base1), .cfg_count(cfg_count),
        .per_req(per_req), .per_data(per_data), .per_ack(per_ack),
        .mem_addr(mem_addr), .mem_data(mem_data), .mem_valid(mem_valid),
        .mem_ready(mem_ready), .clr_valid(clr_valid), .clr_mask(clr_mask),
        .tc_flag(tc_flag), .overrun(overrun), .buffer(buffer)
    );

    assign per_data = src_q;

    always @(posedge clk) begin
        if (per_req && per_ack) begin
            src_q <= src_q + 32'd1;
            nack  <= nack + 1;
        end
        if (mem_valid && mem_ready && nwr < 64) begin
            log_addr[nwr] <= mem_addr;
            log_data[nwr] <= mem_data;
            nwr <= nwr + 1;
        end
    end

    task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_writes(input int target);
        for (int i = 0; i < 500 && nwr < target; i++) @(negedge clk);
    endtask

    task automatic pulse_clear(input logic [7:0] m);
        clr_valid = 1'b1; clr_mask = m;
        @(negedge clk);
        clr_valid = 1'b0; clr_mask = 8'h00;
    endtask

    task automatic t_reset;
        check(mem_valid == 0, "R1 mem_valid", 32'(mem_valid), 0);
        check(per_ack == 0,   "R1 per_ack", 32'(per_ack), 0);
        check(tc_flag == 0,   "R1 tc_flag", 32'(tc_flag), 0);
        check(overrun == 0,   "R1 overrun", 32'(overrun), 0);
        check(buffer == 0,    "R1 buffer", 32'(buffer), 0);
    endtask

    task automatic t_circular;
        cfg_enable = 1'b1; per_req = 1'b1;
        wait_writes(4);
        check(tc_flag == 1, "R4 tc after region 0", 32'(tc_flag), 1);
        check(buffer == 1,  "R3 buffer toggled", 32'(buffer), 1);
        wait_writes(12);
        per_req = 1'b0;
        for (int i = 0; i < 12; i++) begin
            logic [31:0] ea;
            ea = ((i / 4) % 2 == 0 ? 32'h1000 : 32'h2000) + 32'(4 * (i % 4));
            check(log_addr[i] == ea, "R2 R3 write address", log_addr[i], ea);
            check(log_data[i] == 32'h100 + 32'(i), "R2 write data", log_data[i], 32'h100 + 32'(i));
        end
        check(overrun == 1, "R6 overrun latched", 32'(overrun), 1);
        check(buffer == 1,  "R3 buffer after three regions", 32'(buffer), 1);
    endtask

    task automatic t_clear;
        pulse_clear(8'h04);
        check(tc_flag == 1, "R5 foreign bit ignored tc", 32'(tc_flag), 1);
        check(overrun == 1, "R5 foreign bit ignored ovr", 32'(overrun), 1);
        pulse_clear(8'h01);
        check(tc_flag == 0, "R5 tc cleared", 32'(tc_flag), 0);
        check(overrun == 1, "R6 overrun sticky", 32'(overrun), 1);
        pulse_clear(8'h02);
        check(overrun == 0, "R6 overrun cleared", 32'(overrun), 0);
    endtask

    task automatic t_backpressure;
        int acks0;
        acks0 = nack;
        mem_ready = 1'b0; per_req = 1'b1;
        repeat (6) @(negedge clk);
        check(nwr == 12,         "R7 no write while stalled", 32'(nwr), 12);
        check(nack == acks0 + 1, "R7 R8 single ack while stalled", 32'(nack), 32'(acks0 + 1));
        check(mem_valid == 1,    "R7 valid held", 32'(mem_valid), 1);
        check(mem_addr == 32'h2000, "R7 address held", mem_addr, 32'h2000);
        check(mem_data == 32'h10C,  "R7 data held", mem_data, 32'h10C);
        mem_ready = 1'b1;
        wait_writes(13);
        per_req = 1'b0;
        check(log_addr[12] == 32'h2000, "R7 stalled write lands", log_addr[12], 32'h2000);
    endtask

    task automatic t_disable;
        int acks0;
        cfg_enable = 1'b0;
        @(negedge clk);
        check(tc_flag == 1, "R9 partial disable raises tc", 32'(tc_flag), 1);
        acks0 = nack;
        per_req = 1'b1;
        repeat (5) @(negedge clk);
        check(nack == acks0 && mem_valid == 0, "R8 R9 idle no ack", 32'(nack), 32'(acks0));
        per_req = 1'b0;
        pulse_clear(8'h01);
        cfg_count = 16'd2; cfg_enable = 1'b1; per_req = 1'b1;
        @(negedge clk);
        check(buffer == 0, "R9 restart region 0", 32'(buffer), 0);
        wait_writes(15);
        per_req = 1'b0;
        check(log_addr[13] == 32'h1000, "R9 restart at base0", log_addr[13], 32'h1000);
        check(log_addr[14] == 32'h1004, "R2 second word", log_addr[14], 32'h1004);
        check(tc_flag == 1 && buffer == 1, "R3 R4 count 2 swap", {30'd0, tc_flag, buffer}, 32'h3);
        pulse_clear(8'h01);
        cfg_enable = 1'b0;
        repeat (2) @(negedge clk);
        check(tc_flag == 0, "R9 boundary disable no tc", 32'(tc_flag), 0);
    endtask

    task automatic t_zero_count;
        int acks0;
        acks0 = nack;
        cfg_count = 16'd0; cfg_enable = 1'b1; per_req = 1'b1;
        repeat (8) @(negedge clk);
        check(nack == acks0, "R10 zero count no ack", 32'(nack), 32'(acks0));
        check(nwr == 15 && mem_valid == 0, "R10 zero count no write", 32'(nwr), 15);
        per_req = 1'b0; cfg_enable = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_circular();
        t_clear();
        t_backpressure();
        t_disable();
        t_zero_count();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule